// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous SRAM whose data bus never needs an idle cycle between a read and a write. Each cycle may carry one command: a load of an external address with read or write intent, a deselect, or an advance that continues the last loaded operation on the next address of a four-word burst. Commands, addresses and byte-lane write strobes are registered on the rising clock edge, and read data leaves through an output register.

A command presented in cycle n has its data in cycle n+2. A read's word is driven during that cycle. A write's word must be present on the bus during that cycle and is sampled at its closing edge. Reads and writes therefore share one data slot and can be mixed freely. A read that lands on an address whose write data is arriving in the same edge gets that data, merged lane by lane with the stored word. The bidirectional data bus is split into an input, an output and an output-enable, as a pad ring expects. A clock enable freezes the whole block.

Top module: `zt_sram`

## Requirements
- R1: A read loaded in cycle n drives the stored word on `q_out` with `q_oe` high during cycle n+2 (with `oe_n` low).
- R2: A write loaded in cycle n takes `d_in` at the closing edge of cycle n+2. Lane i (bits LANE_W*i up to LANE_W*i+LANE_W-1) is written only when `lane_wr_n[i]` was 0 in cycle n; the other lanes keep their contents.
- R3: Any sequence of reads and writes runs on consecutive cycles, and every read returns the newest data, including lanes written by the command one cycle before it.
- R4: While `clk_en` is 0, no state changes: outputs, pipeline, burst state and array all hold until the next cycle with `clk_en` 1.
- R5: A load executes only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Otherwise the cycle is a deselect: nothing is written and the bus is not driven.
- R6: `q_oe` is 0 during the data cycle of a write and during the data cycle of a deselect.
- R7: `oe_n`=1 forces `q_oe` to 0 in the same cycle without clocking, and a read's output register still updates.
- R8: `adv_ld`=1 repeats the last loaded operation (read, write or deselect) on the next burst address, ignoring `wr_n`, the chip selects and `addr`. After reset the last load counts as a deselect.
- R9: With `burst_ilv`=0, the k-th advance after a load at start address S uses low bits (S[1:0]+k) mod 4. Upper bits equal S.
- R10: With `burst_ilv`=1, the k-th advance uses low bits S[1:0] XOR k, with the upper bits of S.
- R11: After reset `q_oe` is 0 and the pipeline holds no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; 0 stalls the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write, 1 = read on a load |
| lane_wr_n | input | LANES | Per-lane write strobe, active low |
| adv_ld | input | 1 | 1 = advance burst, 0 = load `addr` |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address on a load |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | LANES*LANE_W | Write data from the bus |
| q_out | output | LANES*LANE_W | Read data register |
| q_oe | output | 1 | Bus drive enable for `q_out` |

## Verification
The bench builds the block with ADDR_W=4, two lanes of nine bits and a sixteen-word array. This is small enough to write and read every address, to start a burst at every address in both orders, and to place every read directly behind a write to the same and to a neighbouring address. A long random phase then mixes stalls, deselects, partial-lane writes, bursts and output-enable toggling against an arithmetic model of the array and the two-cycle data slot.

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    adv_ld,
  input  logic                    burst_ilv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] q_out,
  output logic                    q_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  logic              s1_v, s1_wr, s2_v, s2_wr;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_m, s2_m;
  logic              b_v, b_wr;
  logic [ADDR_W-1:0] b_a;
  logic [1:0]        b_cnt;
  logic              out_en;
  logic [DW-1:0]     q_r;

  wire       sel  = ~cs1_n & cs2 & ~cs3_n;
  wire [1:0] nxt  = b_cnt + 2'd1;
  wire [1:0] off  = burst_ilv ? (b_a[1:0] ^ nxt) : (b_a[1:0] + nxt);
  wire [ADDR_W-1:0] c_a = adv_ld ? {b_a[ADDR_W-1:2], off} : addr;
  wire       c_v  = adv_ld ? b_v  : sel;
  wire       c_wr = adv_ld ? b_wr : ~wr_n;
  wire       hit  = s2_v & s2_wr & (s2_a == s1_a);
  wire       rd1  = s1_v & ~s1_wr;

  logic [DW-1:0] fwd;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign fwd[g*LANE_W +: LANE_W] = (hit && s2_m[g]) ? d_in[g*LANE_W +: LANE_W]
                                                      : mem[s1_a][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_wr <= 1'b0; s1_a <= '0; s1_m <= '0;
      s2_v <= 1'b0; s2_wr <= 1'b0; s2_a <= '0; s2_m <= '0;
      b_v <= 1'b0; b_wr <= 1'b0; b_a <= '0; b_cnt <= '0;
      out_en <= 1'b0; q_r <= '0;
    end else if (clk_en) begin
      s1_v <= c_v; s1_wr <= c_wr; s1_a <= c_a; s1_m <= ~lane_wr_n;
      s2_v <= s1_v; s2_wr <= s1_wr; s2_a <= s1_a; s2_m <= s1_m;
      if (!adv_ld) begin
        b_v <= sel; b_wr <= ~wr_n; b_a <= addr; b_cnt <= '0;
      end else begin
        b_cnt <= nxt;
      end
      out_en <= rd1;
      if (rd1) q_r <= fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en && s2_v && s2_wr) begin
      for (int i = 0; i < LANES; i++)
        if (s2_m[i]) mem[s2_a][i*LANE_W +: LANE_W] <= d_in[i*LANE_W +: LANE_W];
    end
  end

  assign q_out = q_r;
  assign q_oe  = out_en & ~oe_n;

  assert_read_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && rd1 |=> out_en);
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(q_out) && $stable(out_en) && $stable(s1_a) && $stable(b_cnt));
  assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv_ld && !sel |=> !s1_v);
  assert_no_drive_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v && s2_wr |-> !out_en);
  assert_burst_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv_ld && s1_v |=> s1_a[ADDR_W-1:2] == $past(s1_a[ADDR_W-1:2]));
endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;
  localparam int AW = 4;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = LW * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1, wr_n = 1'b1;
  logic [NL-1:0] lane_wr_n = '1;
  logic adv_ld = 1'b0, burst_ilv = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_out;
  logic q_oe;

  always #4 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .adv_ld(adv_ld), .burst_ilv(burst_ilv),
    .addr(addr), .oe_n(oe_n), .d_in(d_in), .q_out(q_out), .q_oe(q_oe));

  int errs = 0, checks = 0, cyc = 0;
  logic [DW-1:0] ref_mem [1<<AW];
  int pk [2];
  logic [AW-1:0] pa [2];
  logic [NL-1:0] pm [2];
  logic [DW-1:0] pd [2];
  logic [DW-1:0] pexp [2];
  string ptag [2];
  int bk = 0;
  logic [AW-1:0] ba = '0;
  logic [1:0] bc = '0;
  bit last_en = 1'b1;

  task automatic chk(input bit ok, input string tg, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tg, cyc, act, exp);
    end
  endtask

  task automatic do_check();
    bit eo;
    string tg;
    eo = (pk[1] == 1) && !oe_n;
    if (!last_en) tg = "R4";
    else if (pk[1] == 1 && oe_n) tg = "R7";
    else if (pk[1] == 2) tg = "R6";
    else tg = ptag[1];
    chk(q_oe == eo, tg, DW'(q_oe), DW'(eo));
    if (pk[1] == 1) chk(q_out == pexp[1], last_en ? ptag[1] : "R4", q_out, pexp[1]);
  endtask

  // kind: 0 deselect load, 1 read load, 2 write load, 3 advance
  task automatic cmd(input bit en, input int kind, input logic [AW-1:0] a,
                     input logic [NL-1:0] lanes, input bit ilv, input bit oen, input string tag);
    int nk;
    logic [AW-1:0] na;
    string nt;
    logic [1:0] o;
    @(negedge clk);
    do_check();
    cyc++;
    clk_en = en; adv_ld = (kind == 3); burst_ilv = ilv; oe_n = oen;
    lane_wr_n = ~lanes; addr = a;
    cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
    wr_n = !(kind == 2 || kind == 0);
    if (kind == 0) begin
      if (a % 3 == 0) cs1_n = 1'b1; else if (a % 3 == 1) cs2 = 1'b0; else cs3_n = 1'b1;
    end
    if (kind == 3) begin cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; wr_n = 1'b1; end
    d_in = (pk[1] == 2) ? pd[1] : DW'(32'h15A5A ^ cyc);
    nk = kind; na = a; nt = tag;
    if (en) begin
      if (kind == 3) begin
        bc = bc + 2'd1;
        o = ilv ? (ba[1:0] ^ bc) : (ba[1:0] + bc);
        na = {ba[AW-1:2], o};
        nk = bk;
        nt = (bk == 0) ? "R8" : (ilv ? "R10" : "R9");
      end else begin
        bk = kind; ba = a; bc = 2'd0;
      end
    end
    @(posedge clk);
    last_en = en;
    if (en) begin
      if (pk[1] == 2)
        for (int i = 0; i < NL; i++)
          if (pm[1][i]) ref_mem[pa[1]][i*LW +: LW] = pd[1][i*LW +: LW];
      if (pk[0] == 1) pexp[0] = ref_mem[pa[0]];
      pk[1] = pk[0]; pa[1] = pa[0]; pm[1] = pm[0]; pd[1] = pd[0]; pexp[1] = pexp[0]; ptag[1] = ptag[0];
      pk[0] = nk; pa[0] = na; pm[0] = lanes; pd[0] = DW'($urandom); ptag[0] = nt;
    end
  endtask

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin pk[i] = 0; pa[i] = '0; pm[i] = '0; pd[i] = '0; pexp[i] = '0; ptag[i] = "R11"; end
    for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmd(1, 3, 0, 2'b11, 0, 0, "R8");
    cmd(1, 3, 0, 2'b11, 0, 0, "R8");
    cmd(1, 0, 1, 2'b11, 0, 0, "R11");
    // full writes, then reads: R1, R2
    for (int a = 0; a < 16; a++) cmd(1, 2, AW'(a), 2'b11, 0, 0, "R2");
    for (int a = 0; a < 16; a++) cmd(1, 1, AW'(a), 2'b00, 0, 0, "R1");
    for (int a = 0; a < 16; a++) cmd(1, 2, AW'(a), (a % 2) ? 2'b01 : 2'b10, 0, 0, "R2");
    for (int a = 0; a < 16; a++) cmd(1, 1, AW'(a), 2'b00, 0, 0, "R2");
    // back-to-back mix with forwarding: R3
    for (int a = 0; a < 16; a++) begin
      cmd(1, 2, AW'(a), 2'b11, 0, 0, "R3");
      cmd(1, 1, AW'(a), 2'b00, 0, 0, "R3");
      cmd(1, 1, AW'(a ^ 1), 2'b00, 0, 0, "R3");
      cmd(1, 2, AW'(a ^ 1), 2'b01, 0, 0, "R3");
      cmd(1, 1, AW'(a ^ 1), 2'b00, 0, 0, "R3");
      cmd(1, 2, AW'(a), 2'b10, 0, 0, "R3");
      cmd(1, 2, AW'(a), 2'b01, 0, 0, "R3");
      cmd(1, 1, AW'(a), 2'b00, 0, 0, "R3");
    end
    // deselected writes have no effect: R5
    for (int a = 0; a < 16; a++) begin
      cmd(1, 0, AW'(a), 2'b11, 0, 0, "R5");
      cmd(1, 1, AW'(a), 2'b00, 0, 0, "R5");
    end
    // bursts in both orders from every start: R8 R9 R10
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++) begin
        cmd(1, 2, AW'(a), 2'b11, m[0], 0, "R8");
        for (int k = 0; k < 3; k++) cmd(1, 3, 0, 2'b11, m[0], 0, "R8");
        cmd(1, 1, AW'(a), 2'b00, m[0], 0, "R8");
        for (int k = 0; k < 3; k++) cmd(1, 3, 0, 2'b00, m[0], 0, "R8");
        cmd(1, 0, AW'(a), 2'b11, m[0], 0, "R5");
        cmd(1, 3, 0, 2'b11, m[0], 0, "R8");
      end
    // stalls and output enable: R4 R7
    for (int a = 0; a < 8; a++) begin
      cmd(1, 1, AW'(a), 2'b00, 0, a[0], "R7");
      cmd(0, 2, AW'(a + 1), 2'b11, 0, 0, "R4");
      cmd(0, 1, AW'(a + 2), 2'b00, 0, 1, "R4");
      cmd(1, 2, AW'(a), 2'b11, 0, 0, "R4");
      cmd(1, 1, AW'(a), 2'b00, 0, 1, "R7");
      cmd(0, 1, AW'(a), 2'b00, 0, 0, "R4");
      cmd(1, 1, AW'(a), 2'b00, 0, 0, "R4");
    end
    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 9);
      cmd(($urandom_range(0, 9) != 0), (r < 1) ? 0 : (r < 4) ? 1 : (r < 7) ? 2 : 3,
          AW'($urandom), NL'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0), "R3");
    end
    repeat (3) cmd(1, 0, 0, 2'b11, 0, 0, "R5");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule